// File: doc/BRIEF.md
# Data-Ready Acknowledge Flag Unit

This block collects new-data events from four filter channels into one sticky flag per channel and folds those flags into a single acknowledge pin. A flag is raised by a one-cycle new-data pulse from its channel. It is dropped when that channel's data register is read. The pin shows the active level while any flag is up. It goes back to the inactive level only once every flag is clear.

A channel can be configured so that it never raises its flag:
- its acknowledge-enable bit is low;
- both of its filter stages (sinc and integrator) are switched off;
- both of its oversampling ratios are one.

These conditions only stop a flag from being set. A flag that is already up stays up until its data register is read. A global polarity bit selects whether the pin is active high or active low. The flags are also presented as a 4-bit status field, which the interrupt register reads.

Top module: `ack_flag_unit`

## Requirements
- R1: During and after reset, before any new-data pulse, `flag_status` reads 0 and `ack_pin` equals `ack_pol`, which is the inactive level.
- R2: On a qualified channel c, a high `new_data[c]` at a rising edge sets `flag_status[c]` (bit c belongs to channel c) after that same edge. A channel is qualified when its acknowledge enable is high, at least one stage is enabled, and the two ratios are not both one.
- R3: While `ack_en[c]` is low, `new_data[c]` does not set flag c.
- R4: While `sinc_en[c]` and `integ_en[c]` are both low, `new_data[c]` does not set flag c.
- R5: The oversampling ratios are unsigned integers, held for channel c in bits [c*OSR_W +: OSR_W] of `sinc_osr` and `integ_osr`. When both of channel c's values equal 1, `new_data[c]` does not set flag c.
- R6: A high `data_rd[c]` at an edge with no set on channel c clears flag c after that edge. It leaves the flags of all other channels unchanged, and it has no effect on a flag that is already clear.
- R7: When `new_data[c]` and `data_rd[c]` are both high at the same edge on a qualified channel, flag c is set after that edge.
- R8: With PIN_REG=0, `ack_pin` is at its active level in every cycle in which any flag is set. It is at its inactive level only when all flags are clear. With PIN_REG=1 the pin lags the flags by one cycle.
- R9: With `ack_pol`=0 the pin is active high. With `ack_pol`=1 the pin is inverted, so it is active low.
- R10: The qualification inputs gate only the setting of a flag. A set flag stays set through any change of `ack_en`, `sinc_en`, `integ_en` or the ratios until its channel's data register is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| new_data | input | NCH | Per-channel one-cycle new-data pulse |
| data_rd | input | NCH | Per-channel data-register read strobe |
| ack_en | input | NCH | Per-channel acknowledge enable |
| sinc_en | input | NCH | Per-channel sinc stage enable |
| integ_en | input | NCH | Per-channel integrator stage enable |
| sinc_osr | input | NCH*OSR_W | Per-channel sinc oversampling ratio |
| integ_osr | input | NCH*OSR_W | Per-channel integrator oversampling ratio |
| ack_pol | input | 1 | Pin polarity, 1 inverts the pin |
| flag_status | output | NCH | Flag per channel, for the interrupt register |
| ack_pin | output | 1 | Combined acknowledge pin |

## Verification
Whether a flag sets depends jointly on five configuration fields per channel. A wrong gate may show up only in a single combination, such as one stage off while both ratios are one. To reach all of these cases, the bench sweeps every combination of the enables and of three ratio values on each channel in turn, alternating the polarity across the sweep. The harder case is a new-data pulse that lands on the same edge as a read. The bench drives both strobes in one cycle, and separately shows that a flag survives a configuration change that would have blocked it from setting.

// File: rtl/ack_pkg.sv
package ack_pkg;

   // Pin polarity encoding carried by ack_pol
   typedef enum logic {
      PIN_ACTIVE_HIGH = 1'b0,
      PIN_ACTIVE_LOW  = 1'b1
   } pin_pol_e;

   // Per-channel enable bundle
   typedef struct packed {
      logic ack_en;
      logic sinc_en;
      logic integ_en;
   } chan_en_t;

endpackage

// File: rtl/ack_qual.sv
module ack_qual #(
   parameter int OSR_W = 8
) (
   input  ack_pkg::chan_en_t  en_i,
   input  logic [OSR_W-1:0]   sinc_osr_i,
   input  logic [OSR_W-1:0]   integ_osr_i,
   output logic               qual_o
);

   localparam logic [OSR_W-1:0] UNITY = OSR_W'(1);

   logic any_stage;
   logic both_unity;

   always_comb begin
      any_stage  = en_i.sinc_en | en_i.integ_en;
      both_unity = (sinc_osr_i == UNITY) && (integ_osr_i == UNITY);
      qual_o     = en_i.ack_en & any_stage & ~both_unity;
   end

endmodule

// File: rtl/ack_flag_cell.sv
module ack_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic rd_i,
   output logic flag_o
);

   logic flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (set_req)
         flag_q <= 1'b1;
      else if (rd_i)
         flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   // R2
   set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_req |=> flag_o);

   // R6
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !set_req) |=> !flag_o);

   // R7
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && set_req) |=> flag_o);

   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !rd_i) |=> flag_o);

endmodule

// File: rtl/ack_pin_drive.sv
module ack_pin_drive #(
   parameter int NCH     = 4,
   parameter bit PIN_REG = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] flags_i,
   input  logic           pol_i,
   output logic           pin_o
);

   logic any_set;
   logic active;

   assign any_set = |flags_i;

   generate
      if (PIN_REG) begin : g_reg
         logic act_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               act_q <= 1'b0;
            else
               act_q <= any_set;
         end
         assign active = act_q;

         // R8
         idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_i == '0) |=> (pin_o == pol_i));
         // R8
         busy_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_i != '0) |=> (pin_o != pol_i));
      end else begin : g_comb
         assign active = any_set;

         // R8
         idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_i == '0) |-> (pin_o == pol_i));
         // R8
         busy_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_i != '0) |-> (pin_o != pol_i));
      end
   endgenerate

   assign pin_o = (pol_i == ack_pkg::PIN_ACTIVE_LOW) ? ~active : active;

endmodule

// File: rtl/ack_flag_unit.sv
module ack_flag_unit #(
   parameter int NCH     = 4,
   parameter int OSR_W   = 8,
   parameter bit PIN_REG = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NCH-1:0]       new_data,
   input  logic [NCH-1:0]       data_rd,
   input  logic [NCH-1:0]       ack_en,
   input  logic [NCH-1:0]       sinc_en,
   input  logic [NCH-1:0]       integ_en,
   input  logic [NCH*OSR_W-1:0] sinc_osr,
   input  logic [NCH*OSR_W-1:0] integ_osr,
   input  logic                 ack_pol,
   output logic [NCH-1:0]       flag_status,
   output logic                 ack_pin
);

   localparam int OSR_BUS_W = NCH * OSR_W;

   generate
      if (NCH < 1) begin : g_bad_nch
         $error("ack_flag_unit: NCH must be at least 1");
      end
      if (OSR_W < 1) begin : g_bad_osr
         $error("ack_flag_unit: OSR_W must be at least 1");
      end
      if (OSR_BUS_W != $bits(sinc_osr)) begin : g_bad_bus
         $error("ack_flag_unit: ratio bus width mismatch");
      end
   endgenerate

   logic [NCH-1:0] qual;
   logic [NCH-1:0] flags;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      ack_pkg::chan_en_t en;
      assign en.ack_en   = ack_en[c];
      assign en.sinc_en  = sinc_en[c];
      assign en.integ_en = integ_en[c];

      ack_qual #(.OSR_W(OSR_W)) u_qual (
         .en_i        (en),
         .sinc_osr_i  (sinc_osr[c*OSR_W +: OSR_W]),
         .integ_osr_i (integ_osr[c*OSR_W +: OSR_W]),
         .qual_o      (qual[c])
      );

      ack_flag_cell u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_req (new_data[c] & qual[c]),
         .rd_i    (data_rd[c]),
         .flag_o  (flags[c])
      );

      // R3
      ack_en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!ack_en[c] && !flags[c]) |=> !flags[c]);

      // R4
      stage_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!sinc_en[c] && !integ_en[c] && !flags[c]) |=> !flags[c]);

      // R5
      unity_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ((sinc_osr[c*OSR_W +: OSR_W] == OSR_W'(1)) &&
          (integ_osr[c*OSR_W +: OSR_W] == OSR_W'(1)) && !flags[c]) |=> !flags[c]);
   end

   ack_pin_drive #(.NCH(NCH), .PIN_REG(PIN_REG)) u_pin (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags_i (flags),
      .pol_i   (ack_pol),
      .pin_o   (ack_pin)
   );

   assign flag_status = flags;

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (flag_status == '0));

endmodule

// File: tb/sim_ack_flag_unit.sv
module sim_ack_flag_unit;

   localparam int NCH   = 4;
   localparam int OSR_W = 8;

   logic                 clk = 1'b0;
   logic                 rst_n;
   logic [NCH-1:0]       new_data, data_rd, ack_en, sinc_en, integ_en;
   logic [NCH*OSR_W-1:0] sinc_osr, integ_osr;
   logic                 ack_pol;
   logic [NCH-1:0]       flag_status;
   logic                 ack_pin;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   ack_flag_unit #(.NCH(NCH), .OSR_W(OSR_W), .PIN_REG(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .new_data(new_data), .data_rd(data_rd),
      .ack_en(ack_en), .sinc_en(sinc_en), .integ_en(integ_en),
      .sinc_osr(sinc_osr), .integ_osr(integ_osr), .ack_pol(ack_pol),
      .flag_status(flag_status), .ack_pin(ack_pin)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cfg_all_on();
      ack_en = '1; sinc_en = '1; integ_en = '1;
      for (int c = 0; c < NCH; c++) begin
         sinc_osr[c*OSR_W +: OSR_W]  = 8'd4;
         integ_osr[c*OSR_W +: OSR_W] = 8'd2;
      end
   endtask

   task automatic strobe(input logic [NCH-1:0] nd, input logic [NCH-1:0] rd);
      @(negedge clk);
      new_data = nd; data_rd = rd;
      @(negedge clk);
      new_data = '0; data_rd = '0;
   endtask

   initial begin
      #(20 * 200000);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; new_data = '0; data_rd = '0; ack_pol = 1'b0;
      cfg_all_on();
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 flags in reset", int'(flag_status), 0);
      check("R1 pin in reset pol0", int'(ack_pin), 0);
      ack_pol = 1'b1;
      #1 check("R1 pin in reset pol1", int'(ack_pin), 1);
      ack_pol = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check("R1 flags after reset", int'(flag_status), 0);
      check("R1 pin after reset", int'(ack_pin), 0);

      // Sweep: R2 R3 R4 R5 R9
      for (int ch = 0; ch < NCH; ch++) begin
         for (int k = 0; k < 72; k++) begin
            logic ae, se, ie, exp_f, pol;
            int so, io;
            string tag;
            ae = k[0]; se = k[1]; ie = k[2];
            so = (k / 8) % 3; io = (k / 24) % 3;
            so = (so == 0) ? 1 : (so == 1) ? 2 : 7;
            io = (io == 0) ? 1 : (io == 1) ? 2 : 7;
            pol = k[3] ^ ch[0];
            cfg_all_on();
            ack_en[ch] = ae; sinc_en[ch] = se; integ_en[ch] = ie;
            sinc_osr[ch*OSR_W +: OSR_W]  = OSR_W'(so);
            integ_osr[ch*OSR_W +: OSR_W] = OSR_W'(io);
            ack_pol = pol;
            exp_f = ae && (se || ie) && !(so == 1 && io == 1);
            if (!ae) tag = "R3";
            else if (!(se || ie)) tag = "R4";
            else if (so == 1 && io == 1) tag = "R5";
            else tag = "R2";
            strobe(NCH'(1) << ch, '0);
            check({tag, " sweep flags"}, int'(flag_status), exp_f ? (1 << ch) : 0);
            check("R9 sweep pin", int'(ack_pin), int'(exp_f ^ pol));
            strobe('0, NCH'(1) << ch);
            check("R6 sweep clear", int'(flag_status), 0);
         end
      end

      cfg_all_on(); ack_pol = 1'b0;
      // R7 same-cycle new data and read
      strobe(4'b0010, 4'b0010);
      check("R7 set wins over read", int'(flag_status), 2);
      strobe('0, 4'b0010);
      check("R7 later read clears", int'(flag_status), 0);

      // R6 / R8 read clears only own channel; pin until all clear
      strobe(4'b0101, '0);
      check("R8 two flags", int'(flag_status), 5);
      check("R8 pin active", int'(ack_pin), 1);
      strobe('0, 4'b0001);
      check("R6 own channel only", int'(flag_status), 4);
      check("R8 pin still active", int'(ack_pin), 1);
      strobe('0, 4'b1000);
      check("R6 read of clear channel", int'(flag_status), 4);
      strobe('0, 4'b0100);
      check("R6 last read clears", int'(flag_status), 0);
      check("R8 pin inactive", int'(ack_pin), 0);

      // R9 inverted pin with a flag set
      ack_pol = 1'b1;
      strobe(4'b1000, '0);
      check("R9 inverted active", int'(ack_pin), 0);

      // R10 flag survives disqualifying configuration
      @(negedge clk);
      ack_en = '0; sinc_en = '0; integ_en = '0;
      sinc_osr[3*OSR_W +: OSR_W] = 8'd1; integ_osr[3*OSR_W +: OSR_W] = 8'd1;
      repeat (3) @(negedge clk);
      check("R10 flag held", int'(flag_status), 8);
      check("R10 pin held", int'(ack_pin), 0);
      strobe('0, 4'b1000);
      check("R10 read clears", int'(flag_status), 0);
      check("R9 inverted idle", int'(ack_pin), 1);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule